// File: doc/BRIEF.md
# Framed SPI Command Receiver with Response Sizing

This block is the front end of a packetized serial command link on the controller side. A bit-level shifter upstream delivers whole bytes, each with a one-cycle strobe, while the host holds a chip-select line high for the length of one transaction. The receiver parses a 4-byte little-endian header that carries a 16-bit opcode and then a 16-bit payload length. It forwards the payload bytes, tagged with the buffer slot they belong to, and queues the finished command for the processing side.

Each queued command carries its opcode, its length and a response length. The response length comes from a small opcode lookup. The reset opcode maps to a fixed short response, the connection-request opcode maps to a fixed 8-byte response, and every other opcode echoes its own command length. Header storage is split into a parameterized number of slots. With the default of two, the host can send a second command while the first is still being executed. A slot is released only when the processing side pulses its done input.

Top module: `cmdrx_top`

## Requirements
- R1: After reset, cmdValid, payValid and busyErr are all 0.
- R2: The four header bytes are decoded in this order: opcode bits 7:0, opcode bits 15:8, length bits 7:0, length bits 15:8.
- R3: If the opcode equals RESET_OPC (default 16'h0C03), cmdRespLen is RESET_RSP (default 2).
- R4: If the opcode equals CONN_OPC (default 16'h200D), cmdRespLen is CONN_RSP (default 8).
- R5: For any other opcode, cmdRespLen equals the parsed command length.
- R6: Payload bytes that arrive while chip select is high are forwarded on payData, with payValid high, one cycle after they are accepted. At most the parsed length of bytes is forwarded, and each forwarded byte carries the index of its slot on paySlot.
- R7: Payload bytes beyond the parsed length are not forwarded. They set cmdOverlen for that command, and the command is still queued when chip select falls.
- R8: If chip select falls before all four header bytes have arrived, no command is produced and the slot is returned to the free pool.
- R9: A second frame is accepted into a different slot while the first command is still unaccepted or unfinished.
- R10: If every slot is occupied when chip select rises, the frame is dropped: none of its payload is forwarded and no command is queued. busyErr is then set and stays set until reset.
- R11: Commands are offered in arrival order through the cmdValid/cmdReady handshake. While cmdReady is low, cmdValid and the command fields hold steady.
- R12: A procDone pulse frees the oldest accepted command's slot, after which a new frame is accepted again.
- R13: cmdValid rises in the cycle after chip select is seen low at the end of a complete frame, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frameSel | input | 1 | Chip select, high for the duration of a frame |
| byteValid | input | 1 | Strobe marking byteIn as a received byte |
| byteIn | input | 8 | Deserialized byte |
| payValid | output | 1 | Forwarded payload byte valid |
| payData | output | 8 | Forwarded payload byte |
| paySlot | output | SLOT_W | Slot index the payload byte belongs to |
| cmdValid | output | 1 | A parsed command is offered |
| cmdReady | input | 1 | Processing side accepts the offered command |
| cmdOpcode | output | 16 | Opcode of the offered command |
| cmdLength | output | 16 | Parsed payload length |
| cmdRespLen | output | 16 | Response length chosen by the lookup |
| cmdOverlen | output | 1 | The frame carried more payload than its length |
| cmdSlot | output | SLOT_W | Slot holding the offered command |
| procDone | input | 1 | Processing of the oldest accepted command has finished |
| busyErr | output | 1 | Sticky: a frame was dropped because all slots were full |

## Verification
The bench builds the block with its defaults: two slots and the default opcode values. With only two slots, a third frame sent before any done pulse reaches the overflow path, so the drop case and the later recovery both occur within a few short frames. Zero-length and short payloads keep every frame small. Because the lookup values are the defaults, both fixed-size responses and the fallback to the command length can be checked against known constants.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;

  typedef struct packed {
    logic       alloc;
    logic       hdrWr;
    logic [1:0] hdrIdx;
    logic       payFwd;
    logic       markExtra;
  } ctrl_strb_t;

  typedef struct packed {
    logic [15:0] opc;
    logic [15:0] len;
    logic        extra;
  } slot_t;

  function automatic logic [15:0] respSize(input logic [15:0] opc, input logic [15:0] len,
                                           input logic [15:0] rstOpc, input logic [15:0] connOpc,
                                           input logic [15:0] rstRsp, input logic [15:0] connRsp);
    if (opc == rstOpc)       return rstRsp;
    else if (opc == connOpc) return connRsp;
    else                     return len;
  endfunction

endpackage

// File: rtl/cmdrx_ctrl.sv
module cmdrx_ctrl
  import cmdrx_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int SLOT_W    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frameSel,
  input  logic              byteValid,
  input  logic [7:0]        byteIn,
  input  logic              cmdReady,
  input  logic              procDone,
  output ctrl_strb_t        strb,
  output logic [SLOT_W-1:0] fillSlot,
  output logic [SLOT_W-1:0] headSlot,
  output logic              cmdValid,
  output logic              busyErr
);
  localparam int CNT_W = $clog2(NUM_SLOTS + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NUM_SLOTS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_PAY, S_DROP} state_t;
  state_t state;

  logic [1:0]       hdrCnt;
  logic [15:0]      payCnt, curLen;
  logic [7:0]       lenLo;
  logic [CNT_W-1:0] occCnt, pendCnt, handCnt;
  logic [SLOT_W-1:0] freePtr;

  logic full, csStart, byteHit, hdrByte, payByte, complete, discard, take, freeEv, reject;
  logic [1:0] idx;

  function automatic logic [SLOT_W-1:0] bump(input logic [SLOT_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + SLOT_W'(1);
  endfunction

  always_comb begin
    full     = (occCnt == FULL_CNT);
    csStart  = (state == S_IDLE) && frameSel;
    reject   = csStart && full;
    byteHit  = byteValid && frameSel;
    hdrByte  = byteHit && ((state == S_HDR) || (csStart && !full));
    idx      = (state == S_IDLE) ? 2'd0 : hdrCnt;
    payByte  = byteHit && (state == S_PAY);
    complete = (state == S_PAY) && !frameSel;
    discard  = (state == S_HDR) && !frameSel;
    cmdValid = (pendCnt != '0);
    take     = cmdValid && cmdReady;
    freeEv   = procDone && (handCnt != '0);
    strb.alloc     = csStart && !full;
    strb.hdrWr     = hdrByte;
    strb.hdrIdx    = idx;
    strb.payFwd    = payByte && (payCnt < curLen);
    strb.markExtra = payByte && !(payCnt < curLen);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      hdrCnt <= '0;
      payCnt <= '0;
      curLen <= '0;
      lenLo <= '0;
    end else begin
      if (hdrByte && idx == 2'd2) lenLo <= byteIn;
      if (hdrByte && idx == 2'd3) curLen <= {byteIn, lenLo};
      case (state)
        S_IDLE: if (frameSel) begin
          if (full) state <= S_DROP;
          else begin
            state  <= S_HDR;
            hdrCnt <= hdrByte ? 2'd1 : 2'd0;
          end
        end
        S_HDR: if (!frameSel) state <= S_IDLE;
               else if (hdrByte) begin
                 if (hdrCnt == 2'd3) begin
                   state  <= S_PAY;
                   payCnt <= '0;
                 end
                 hdrCnt <= hdrCnt + 2'd1;
               end
        S_PAY: if (!frameSel) state <= S_IDLE;
               else if (strb.payFwd) payCnt <= payCnt + 16'd1;
        default: if (!frameSel) state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occCnt <= '0; pendCnt <= '0; handCnt <= '0;
      fillSlot <= '0; headSlot <= '0; freePtr <= '0;
      busyErr <= 1'b0;
    end else begin
      occCnt  <= occCnt + (strb.alloc ? CNT_W'(1) : '0)
                        - (discard ? CNT_W'(1) : '0) - (freeEv ? CNT_W'(1) : '0);
      pendCnt <= pendCnt + (complete ? CNT_W'(1) : '0) - (take ? CNT_W'(1) : '0);
      handCnt <= handCnt + (take ? CNT_W'(1) : '0) - (freeEv ? CNT_W'(1) : '0);
      if (complete) fillSlot <= bump(fillSlot);
      if (take)     headSlot <= bump(headSlot);
      if (freeEv)   freePtr  <= bump(freePtr);
      if (reject)   busyErr  <= 1'b1;
    end
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    occCnt <= FULL_CNT);
  p_busy_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busyErr |=> busyErr);
  p_queue_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pendCnt) + int'(handCnt)) <= int'(occCnt));
  p_drop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DROP) |-> !strb.payFwd && !strb.hdrWr);

endmodule

// File: rtl/cmdrx_data.sv
module cmdrx_data
  import cmdrx_pkg::*;
#(
  parameter int          NUM_SLOTS = 2,
  parameter int          SLOT_W    = 1,
  parameter logic [15:0] RESET_OPC = 16'h0C03,
  parameter logic [15:0] CONN_OPC  = 16'h200D,
  parameter logic [15:0] RESET_RSP = 16'd2,
  parameter logic [15:0] CONN_RSP  = 16'd8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_strb_t        strb,
  input  logic [SLOT_W-1:0] fillSlot,
  input  logic [SLOT_W-1:0] headSlot,
  input  logic [7:0]        byteIn,
  output logic              payValid,
  output logic [7:0]        payData,
  output logic [SLOT_W-1:0] paySlot,
  output logic [15:0]       cmdOpcode,
  output logic [15:0]       cmdLength,
  output logic [15:0]       cmdRespLen,
  output logic              cmdOverlen
);
  slot_t slotView [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    slot_t entry;
    logic  hit;
    assign hit = (fillSlot == SLOT_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) entry <= '0;
      else begin
        if (hit && strb.alloc) entry.extra <= 1'b0;
        if (hit && strb.markExtra) entry.extra <= 1'b1;
        if (hit && strb.hdrWr) begin
          case (strb.hdrIdx)
            2'd0: entry.opc[7:0]  <= byteIn;
            2'd1: entry.opc[15:8] <= byteIn;
            2'd2: entry.len[7:0]  <= byteIn;
            default: entry.len[15:8] <= byteIn;
          endcase
        end
      end
    end
    assign slotView[g] = entry;
  end

  slot_t head;
  always_comb begin
    head       = slotView[headSlot];
    cmdOpcode  = head.opc;
    cmdLength  = head.len;
    cmdOverlen = head.extra;
    cmdRespLen = respSize(head.opc, head.len, RESET_OPC, CONN_OPC, RESET_RSP, CONN_RSP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      payValid <= 1'b0;
      payData  <= '0;
      paySlot  <= '0;
    end else begin
      payValid <= strb.payFwd;
      if (strb.payFwd) begin
        payData <= byteIn;
        paySlot <= fillSlot;
      end
    end
  end

endmodule

// File: rtl/cmdrx_top.sv
module cmdrx_top
  import cmdrx_pkg::*;
#(
  parameter int          NUM_SLOTS = 2,
  parameter logic [15:0] RESET_OPC = 16'h0C03,
  parameter logic [15:0] CONN_OPC  = 16'h200D,
  parameter logic [15:0] RESET_RSP = 16'd2,
  parameter logic [15:0] CONN_RSP  = 16'd8,
  localparam int         SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frameSel,
  input  logic              byteValid,
  input  logic [7:0]        byteIn,
  output logic              payValid,
  output logic [7:0]        payData,
  output logic [SLOT_W-1:0] paySlot,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [15:0]       cmdOpcode,
  output logic [15:0]       cmdLength,
  output logic [15:0]       cmdRespLen,
  output logic              cmdOverlen,
  output logic [SLOT_W-1:0] cmdSlot,
  input  logic              procDone,
  output logic              busyErr
);
  ctrl_strb_t        strb;
  logic [SLOT_W-1:0] fillSlot, headSlot;

  cmdrx_ctrl #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frameSel(frameSel), .byteValid(byteValid), .byteIn(byteIn),
    .cmdReady(cmdReady), .procDone(procDone), .strb(strb), .fillSlot(fillSlot),
    .headSlot(headSlot), .cmdValid(cmdValid), .busyErr(busyErr));

  cmdrx_data #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .RESET_OPC(RESET_OPC),
               .CONN_OPC(CONN_OPC), .RESET_RSP(RESET_RSP), .CONN_RSP(CONN_RSP)) u_data (
    .clk(clk), .rst_n(rst_n), .strb(strb), .fillSlot(fillSlot), .headSlot(headSlot),
    .byteIn(byteIn), .payValid(payValid), .payData(payData), .paySlot(paySlot),
    .cmdOpcode(cmdOpcode), .cmdLength(cmdLength), .cmdRespLen(cmdRespLen),
    .cmdOverlen(cmdOverlen));

  assign cmdSlot = headSlot;

  p_hold_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdOpcode) && $stable(cmdLength));
  p_pay_framed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    payValid |-> $past(frameSel));

endmodule

// File: tb/sim_cmdrx_top.sv
module sim_cmdrx_top;
  localparam logic [15:0] RST_OPC  = 16'h0C03;
  localparam logic [15:0] CONN_OPC = 16'h200D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frameSel = 1'b0, byteValid = 1'b0, cmdReady = 1'b0, procDone = 1'b0;
  logic [7:0] byteIn = '0;
  logic payValid, cmdValid, cmdOverlen, busyErr;
  logic [7:0] payData;
  logic [0:0] paySlot, cmdSlot;
  logic [15:0] cmdOpcode, cmdLength, cmdRespLen;

  int errors = 0, checks = 0, payCount = 0;
  logic [7:0] payLog [64];
  logic [0:0] lastSlot;
  bit finished = 0;

  always #10 clk = ~clk;

  cmdrx_top u0 (
    .clk(clk), .rst_n(rst_n), .frameSel(frameSel), .byteValid(byteValid), .byteIn(byteIn),
    .payValid(payValid), .payData(payData), .paySlot(paySlot), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdOpcode(cmdOpcode), .cmdLength(cmdLength),
    .cmdRespLen(cmdRespLen), .cmdOverlen(cmdOverlen), .cmdSlot(cmdSlot),
    .procDone(procDone), .busyErr(busyErr));

  always @(negedge clk) if (rst_n && payValid) begin
    if (payCount < 64) payLog[payCount] = payData;
    lastSlot = paySlot;
    payCount++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic startFrame(input logic [15:0] opc, input logic [15:0] len, input int nPay);
    frameSel = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4 + nPay; i++) begin
      case (i)
        0: byteIn = opc[7:0];
        1: byteIn = opc[15:8];
        2: byteIn = len[7:0];
        3: byteIn = len[15:8];
        default: byteIn = 8'hA0 + 8'(i - 4);
      endcase
      byteValid = 1'b1;
      @(negedge clk);
    end
    byteValid = 1'b0;
  endtask

  task automatic endFrame();
    frameSel = 1'b0;
    @(negedge clk);
  endtask

  task automatic take();
    cmdReady = 1'b1; @(negedge clk); cmdReady = 1'b0;
  endtask

  task automatic finishCmd();
    procDone = 1'b1; @(negedge clk); procDone = 1'b0;
  endtask

  task automatic t_reset();
    chk(cmdValid == 1'b0, "R1 cmdValid", int'(cmdValid), 0);
    chk(payValid == 1'b0, "R1 payValid", int'(payValid), 0);
    chk(busyErr == 1'b0, "R1 busyErr", int'(busyErr), 0);
  endtask

  task automatic t_basic();
    int p0 = payCount;
    startFrame(16'h1234, 16'd3, 3);
    chk(cmdValid == 1'b0, "R13 early", int'(cmdValid), 0);
    endFrame();
    chk(cmdValid == 1'b1, "R13 valid", int'(cmdValid), 1);
    chk(cmdOpcode == 16'h1234, "R2 opcode", int'(cmdOpcode), 'h1234);
    chk(cmdLength == 16'd3, "R2 length", int'(cmdLength), 3);
    chk(cmdRespLen == 16'd3, "R5 resp", int'(cmdRespLen), 3);
    chk(payCount - p0 == 3, "R6 count", payCount - p0, 3);
    chk(payLog[p0] == 8'hA0 && payLog[p0+2] == 8'hA2, "R6 data",
        int'(payLog[p0+2]), 'hA2);
    chk(lastSlot == cmdSlot, "R6 slot", int'(lastSlot), int'(cmdSlot));
    take();
    chk(cmdValid == 1'b0, "R11 taken", int'(cmdValid), 0);
    finishCmd();
  endtask

  task automatic t_lookup();
    startFrame(RST_OPC, 16'd0, 0); endFrame();
    chk(cmdRespLen == 16'd2, "R3 resp", int'(cmdRespLen), 2);
    take(); finishCmd();
    startFrame(CONN_OPC, 16'd5, 5); endFrame();
    chk(cmdRespLen == 16'd8, "R4 resp", int'(cmdRespLen), 8);
    chk(cmdLength == 16'd5, "R2 length2", int'(cmdLength), 5);
    take(); finishCmd();
    startFrame(16'h0300, 16'h0102, 0); endFrame();
    chk(cmdRespLen == 16'h0102, "R5 wide", int'(cmdRespLen), 'h0102);
    take(); finishCmd();
  endtask

  task automatic t_extra();
    int p0 = payCount;
    startFrame(16'h0042, 16'd2, 4); endFrame();
    chk(payCount - p0 == 2, "R7 count", payCount - p0, 2);
    chk(cmdValid == 1'b1, "R7 queued", int'(cmdValid), 1);
    chk(cmdOverlen == 1'b1, "R7 flag", int'(cmdOverlen), 1);
    take(); finishCmd();
  endtask

  task automatic t_partial();
    int p0 = payCount;
    startFrame(16'h5555, 16'd0, 0);
    frameSel = 1'b0;
    frameSel = 1'b1; @(negedge clk);
    byteIn = 8'h11; byteValid = 1'b1; @(negedge clk);
    byteIn = 8'h22; @(negedge clk);
    byteValid = 1'b0;
    endFrame();
    chk(cmdValid == 1'b1, "R8 prior", int'(cmdValid), 1);
    take(); finishCmd();
    frameSel = 1'b1; @(negedge clk);
    byteIn = 8'h33; byteValid = 1'b1; @(negedge clk);
    byteValid = 1'b0;
    endFrame();
    repeat (3) @(negedge clk);
    chk(cmdValid == 1'b0, "R8 none", int'(cmdValid), 0);
    chk(payCount == p0, "R8 nopay", payCount - p0, 0);
  endtask

  task automatic t_double_full();
    logic [0:0] sA;
    int p0;
    startFrame(16'h0A0A, 16'd1, 1); endFrame(); sA = lastSlot;
    startFrame(16'h0B0B, 16'd1, 1); endFrame();
    chk(busyErr == 1'b0, "R9 accepted", int'(busyErr), 0);
    chk(lastSlot != sA, "R9 slot", int'(lastSlot), int'(~sA));
    chk(cmdOpcode == 16'h0A0A, "R11 order", int'(cmdOpcode), 'h0A0A);
    repeat (3) @(negedge clk);
    chk(cmdValid && cmdOpcode == 16'h0A0A, "R11 hold", int'(cmdOpcode), 'h0A0A);
    p0 = payCount;
    startFrame(16'h0C0C, 16'd2, 2); endFrame();
    chk(busyErr == 1'b1, "R10 flag", int'(busyErr), 1);
    chk(payCount == p0, "R10 nopay", payCount - p0, 0);
    take();
    chk(cmdOpcode == 16'h0B0B, "R11 second", int'(cmdOpcode), 'h0B0B);
    take();
    chk(cmdValid == 1'b0, "R10 notqueued", int'(cmdValid), 0);
    startFrame(16'h0E0E, 16'd1, 1); endFrame();
    chk(cmdValid == 1'b0, "R12 stillfull", int'(cmdValid), 0);
    finishCmd();
    p0 = payCount;
    startFrame(16'h0D0D, 16'd1, 1); endFrame();
    chk(cmdValid == 1'b1 && cmdOpcode == 16'h0D0D, "R12 freed", int'(cmdOpcode), 'h0D0D);
    chk(payCount - p0 == 1, "R12 pay", payCount - p0, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_lookup();
    t_extra();
    t_partial();
    t_double_full();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule